// File: doc/BRIEF.md
# ISA request demultiplexer

This block turns a few time-shared request pins back into full request vectors for an interrupt controller and a DMA controller. A slow bus clock and a clock at twice its rate run through four phases. During each phase every interrupt pin carries one request, and so does every DMA request pin. At the end of a phase the block samples the pins and holds each value in its own register until the same phase comes round again. The outputs are therefore steady, registered vectors: 16 interrupt lines and 8 DMA request lines at the default sizes.

The two bus clocks are built here from one of two timing sources, and the choice is fixed while reset is applied. All logic runs on one fast system clock. Each source arrives as a one-cycle strobe: `pci_tick` pulses once per PCI clock period, and `osc_edge` pulses once per oscillator edge, rising or falling. One phase step per strobe gives a bus clock of PCI/4 from the first source and oscillator/2 from the second. Interrupt line 8 is inverted on capture, so a real-time clock with an active-low output can drive it directly. DMA channel 4 is the cascade channel and is never reported. The block also compresses the DMA controller's acknowledge vector into a 3-bit channel code.

Top module: `isa_req_demux`

## Requirements
- R1: `src_sel` is captured while `rst` is high (0 = `pci_tick`, 1 = `osc_edge`). Changes to it after reset have no effect, and strobes from the source that was not chosen do not move the phase.
- R2: The phase is the 2-bit value {`isa_clk`, `isa_clkx2`}. It advances by one, modulo 4, on the clock edge at which a strobe from the chosen source is seen, and holds at all other edges.
- R3: When a chosen strobe is seen in phase p, `irq_pins[n]` is stored into `irq_vec[4n+p]`. The new value is visible one clock after that edge.
- R4: A request bit changes only at a strobe that ends its own phase. In every other cycle it holds its last captured value.
- R5: `irq_vec[8]` holds the inverse of the pin level captured for it. Every other interrupt line keeps the polarity of its pin.
- R6: When a chosen strobe is seen in phase p, `drq_pins[n]` is stored into `drq_vec[4n+p]`, with the same timing as R3.
- R7: `drq_vec[4]` is always 0, whatever level its pin carries in phase 0.
- R8: `dack_code` is registered one clock after `dack_vec`. It gives the index of the lowest set bit of `dack_vec`, not counting bit 4. When no other bit is set, the code is 4, meaning no acknowledge. Bit 4 on its own also gives code 4.
- R9: While `rst` is high, phase, `irq_vec` and `drq_vec` all read 0 and `dack_code` reads 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| src_sel | input | 1 | Timing source choice, captured while in reset |
| pci_tick | input | 1 | One pulse per PCI clock period |
| osc_edge | input | 1 | One pulse per oscillator edge |
| irq_pins | input | 4 | Time-shared interrupt request pins |
| drq_pins | input | 2 | Time-shared DMA request pins |
| dack_vec | input | 8 | Acknowledge vector from the DMA controller |
| isa_clk | output | 1 | Bus clock, phase bit 1 |
| isa_clkx2 | output | 1 | Doubled bus clock, phase bit 0 |
| irq_vec | output | 16 | Held interrupt requests |
| drq_vec | output | 8 | Held DMA requests |
| dack_code | output | 3 | Encoded DMA acknowledge channel |

## Verification
The bench builds the block with its default parameters: four interrupt pins, two DMA pins, the inverted line at 8 and the cascade channel at 4. These are the sizes at which the inverted line and the suppressed channel fall on pin 2 phase 0 and pin 1 phase 0. Both timing sources are run. Strobes arrive at random spacing, sometimes in back-to-back cycles, so every phase is seen both with long holds and with captures on consecutive edges. During the run `src_sel` is toggled after reset, and a stretch with every pin held high shows line 8 reading low and channel 4 staying clear.

// File: rtl/isa_demux_pkg.sv
package isa_demux_pkg;
  localparam int PHASES    = 4;
  localparam int PHASE_W   = 2;
  typedef logic [PHASE_W-1:0] phase_t;
endpackage

// File: rtl/isa_clk_gen.sv
module isa_clk_gen
  import isa_demux_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   src_sel,
  input  logic   pci_tick,
  input  logic   osc_edge,
  output phase_t phase,
  output logic   step
);
  logic src_q;

  always_ff @(posedge clk) begin
    if (rst) src_q <= src_sel;
  end

  assign step = src_q ? osc_edge : pci_tick;

  always_ff @(posedge clk) begin
    if (rst)       phase <= '0;
    else if (step) phase <= phase + phase_t'(1);
  end

  assert_src_frozen_R1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(src_q));
  assert_phase_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(phase));
  assert_phase_step_R2: assert property (@(posedge clk) disable iff (rst)
    step |=> phase == $past(phase) + phase_t'(1));
endmodule

// File: rtl/req_sampler.sv
module req_sampler
  import isa_demux_pkg::*;
#(
  parameter int                    PINS      = 4,
  parameter logic [PINS*PHASES-1:0] INV_MASK  = '0,
  parameter logic [PINS*PHASES-1:0] ZERO_MASK = '0
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     step,
  input  phase_t                   phase,
  input  logic [PINS-1:0]          pins,
  output logic [PINS*PHASES-1:0]   lines
);
  localparam int LINES = PINS * PHASES;

  always_ff @(posedge clk) begin
    if (rst) begin
      lines <= '0;
    end else if (step) begin
      for (int n = 0; n < PINS; n++) begin
        for (int p = 0; p < PHASES; p++) begin
          if (phase == phase_t'(p)) begin
            lines[n*PHASES+p] <= ZERO_MASK[n*PHASES+p] ? 1'b0
                                 : (pins[n] ^ INV_MASK[n*PHASES+p]);
          end
        end
      end
    end
  end

  for (genvar gn = 0; gn < PINS; gn++) begin : g_pin
    for (genvar gp = 0; gp < PHASES; gp++) begin : g_ph
      localparam int I = gn * PHASES + gp;
      // R3 R5 R6 R7: captured value follows pin, polarity and forcing rules
      assert_capture_R3: assert property (@(posedge clk) disable iff (rst)
        (step && phase == phase_t'(gp)) |=>
          lines[I] == (ZERO_MASK[I] ? 1'b0 : ($past(pins[gn]) ^ INV_MASK[I])));
      assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !(step && phase == phase_t'(gp)) |=> $stable(lines[I]));
    end
  end

  if (LINES < 1) begin : g_bad
    initial $error("req_sampler needs at least one line");
  end
endmodule

// File: rtl/dack_encoder.sv
module dack_encoder #(
  parameter int CH   = 8,
  parameter int SKIP = 4,
  localparam int CW  = $clog2(CH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CH-1:0] ack_in,
  output logic [CW-1:0] code
);
  localparam logic [CW-1:0] NONE = CW'(SKIP);

  logic [CW-1:0] code_n;
  logic [CH-1:0] live;

  always_comb begin
    live = ack_in;
    live[SKIP] = 1'b0;
    code_n = NONE;
    for (int c = CH - 1; c >= 0; c--) begin
      if (live[c]) code_n = CW'(c);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) code <= NONE;
    else     code <= code_n;
  end

  assert_idle_code_R8: assert property (@(posedge clk) disable iff (rst)
    (ack_in == '0) |=> code == NONE);
  assert_skip_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (ack_in == (CH'(1) << SKIP)) |=> code == NONE);
endmodule

// File: rtl/isa_req_demux.sv
module isa_req_demux
  import isa_demux_pkg::*;
#(
  parameter int IRQ_PINS   = 4,
  parameter int DRQ_PINS   = 2,
  parameter int INV_LINE   = 8,
  parameter int CASCADE_CH = 4,
  localparam int IRQ_LINES = IRQ_PINS * PHASES,
  localparam int DRQ_LINES = DRQ_PINS * PHASES,
  localparam int CODE_W    = $clog2(DRQ_LINES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 src_sel,
  input  logic                 pci_tick,
  input  logic                 osc_edge,
  input  logic [IRQ_PINS-1:0]  irq_pins,
  input  logic [DRQ_PINS-1:0]  drq_pins,
  input  logic [DRQ_LINES-1:0] dack_vec,
  output logic                 isa_clk,
  output logic                 isa_clkx2,
  output logic [IRQ_LINES-1:0] irq_vec,
  output logic [DRQ_LINES-1:0] drq_vec,
  output logic [CODE_W-1:0]    dack_code
);
  localparam logic [IRQ_LINES-1:0] IRQ_INV  = IRQ_LINES'(1) << INV_LINE;
  localparam logic [DRQ_LINES-1:0] DRQ_ZERO = DRQ_LINES'(1) << CASCADE_CH;

  phase_t phase;
  logic   step;

  isa_clk_gen u_clk (
    .clk(clk), .rst(rst), .src_sel(src_sel),
    .pci_tick(pci_tick), .osc_edge(osc_edge),
    .phase(phase), .step(step)
  );

  assign isa_clk   = phase[1];
  assign isa_clkx2 = phase[0];

  req_sampler #(.PINS(IRQ_PINS), .INV_MASK(IRQ_INV), .ZERO_MASK('0)) u_irq (
    .clk(clk), .rst(rst), .step(step), .phase(phase),
    .pins(irq_pins), .lines(irq_vec)
  );

  req_sampler #(.PINS(DRQ_PINS), .INV_MASK('0), .ZERO_MASK(DRQ_ZERO)) u_drq (
    .clk(clk), .rst(rst), .step(step), .phase(phase),
    .pins(drq_pins), .lines(drq_vec)
  );

  dack_encoder #(.CH(DRQ_LINES), .SKIP(CASCADE_CH)) u_ack (
    .clk(clk), .rst(rst), .ack_in(dack_vec), .code(dack_code)
  );
endmodule

// File: tb/test_isa_req_demux.sv
module test_isa_req_demux;
  logic clk = 0, rst = 1, src_sel = 0, pci_tick = 0, osc_edge = 0;
  logic [3:0] irq_pins = 0;
  logic [1:0] drq_pins = 0;
  logic [7:0] dack_vec = 0;
  logic isa_clk, isa_clkx2;
  logic [15:0] irq_vec;
  logic [7:0] drq_vec;
  logic [2:0] dack_code;

  int tests = 0, fails = 0;
  bit done = 0;
  bit force_high = 0;
  bit toggle_src = 0;

  always #2 clk = ~clk;

  isa_req_demux i_isa_req_demux (
    .clk(clk), .rst(rst), .src_sel(src_sel), .pci_tick(pci_tick),
    .osc_edge(osc_edge), .irq_pins(irq_pins), .drq_pins(drq_pins),
    .dack_vec(dack_vec), .isa_clk(isa_clk), .isa_clkx2(isa_clkx2),
    .irq_vec(irq_vec), .drq_vec(drq_vec), .dack_code(dack_code)
  );

  // behavioural reference model
  int src_m = 0, ph_m = 0, code_m = 4;
  logic [15:0] irq_m = 0;
  logic [7:0] drq_m = 0;
  bit in_rst = 1;

  always @(posedge clk) begin
    in_rst = rst;
    if (rst) begin
      src_m = src_sel; ph_m = 0; irq_m = 0; drq_m = 0; code_m = 4;
    end else begin
      if ((src_m != 0) ? osc_edge : pci_tick) begin
        for (int n = 0; n < 4; n++) irq_m[4*n+ph_m] = irq_pins[n] ^ ((4*n+ph_m) == 8);
        for (int n = 0; n < 2; n++) drq_m[4*n+ph_m] = ((4*n+ph_m) == 4) ? 1'b0 : drq_pins[n];
        ph_m = (ph_m + 1) % 4;
      end
      code_m = 4;
      for (int c = 7; c >= 0; c--) if (dack_vec[c] && c != 4) code_m = c;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      if (in_rst) begin
        chk("R9 phase", {isa_clk, isa_clkx2}, 0);
        chk("R9 irq", irq_vec, 0);
        chk("R9 drq", drq_vec, 0);
        chk("R9 code", dack_code, 4);
      end else begin
        chk(toggle_src ? "R1 phase" : "R2 phase", {isa_clk, isa_clkx2}, ph_m);
        chk("R3 R4 irq", irq_vec & ~16'h0100, irq_m & ~16'h0100);
        chk("R5 irq8", irq_vec[8], irq_m[8]);
        chk("R6 drq", drq_vec & ~8'h10, drq_m & ~8'h10);
        chk("R7 drq4", drq_vec[4], 0);
        chk("R8 code", dack_code, code_m);
      end
    end
  end

  task automatic run(input int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      pci_tick = ($urandom_range(0, 2) == 0);
      osc_edge = ($urandom_range(0, 2) == 0);
      if (toggle_src) src_sel = $urandom_range(0, 1);
      irq_pins = force_high ? 4'hF : 4'($urandom_range(0, 15));
      drq_pins = force_high ? 2'h3 : 2'($urandom_range(0, 3));
      case ($urandom_range(0, 3))
        0: dack_vec = 0;
        1: dack_vec = 8'h10;
        2: dack_vec = 8'(1 << $urandom_range(0, 7));
        default: dack_vec = 8'($urandom_range(0, 255));
      endcase
    end
  endtask

  task automatic finish_up;
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    // source 0: PCI strobe
    rst = 1; src_sel = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    toggle_src = 1;
    run(600);
    toggle_src = 0;
    force_high = 1;
    run(40);
    force_high = 0;
    // source 1: oscillator edge strobe
    @(negedge clk);
    rst = 1; src_sel = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    run(300);
    toggle_src = 1;
    run(300);
    toggle_src = 0;
    // back-to-back strobes on every edge
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      osc_edge = 1; pci_tick = 0;
      irq_pins = 4'($urandom_range(0, 15));
      drq_pins = 2'($urandom_range(0, 3));
    end
    @(negedge clk);
    osc_edge = 0;
    repeat (4) @(negedge clk);
    finish_up();
  end

  initial begin
    #200000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_up();
    end
  end
endmodule